// File: doc/BRIEF.md
# Parallel display bus strobe timer

This block runs single read and write transfers on an asynchronous parallel bus toward a display panel. A host hands it one transfer at a time over a valid/ready command port. For each transfer it lowers chip select, sets the direction line and, for writes, the data output enable. It then moves through a setup phase, a strobe phase on the read or write strobe, a hold phase, and an optional turnaround gap before the next transfer may start.

All phase lengths come from one 32-bit configuration word. Reads and writes have separate setup, strobe and hold counts. A single 2-bit turnaround count is shared. The word is captured at the moment a command is accepted. A read returns the bus data through a one-cycle response pulse, and a write ends with a one-cycle done pulse.

Back-pressure rules: a command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. The command fields and `cfg_word` must be stable while `cmd_valid` is high. `cmd_ready` depends only on internal state and never on `cmd_valid`. The response side carries no back-pressure, so the consumer must take `rsp_valid` in the cycle it is high.

Top module: `pbus_strobe_timer`

## Requirements
- R1: Configuration fields, from the top bit down: write setup [31:27], write strobe [26:21], write hold [20:17], read setup [16:12], read strobe [11:6], read hold [5:2], turnaround [1:0].
- R2: After acceptance, `bus_cs_n` is low for exactly the setup count of cycles before the strobe falls. A setup count of 0 makes the strobe fall in the first cycle of chip select.
- R3: The active strobe (low) lasts exactly the strobe count of cycles, and a count of 0 behaves as 1. A strobe is never low while `bus_cs_n` is high.
- R4: After the strobe rises, `bus_cs_n` stays low for exactly the hold count of cycles, and a count of 0 behaves as 1. `bus_dir`, `bus_oe` and `bus_dout` do not change while `bus_cs_n` stays low.
- R5: A write pulses only `bus_wr_n` and uses the write fields. A read pulses only `bus_rd_n` and uses the read fields.
- R6: When the finished access or the next access is a write, and the next command waits at the port, `bus_cs_n` stays high for exactly ta+1 cycles between the two accesses. Here ta is the turnaround field latched with the finished access.
- R7: Between two reads no turnaround is added. With the next read already waiting, `bus_cs_n` is high for exactly 1 cycle.
- R8: `bus_dir` is 1 during a read access and 0 during a write access. `bus_oe` is 1 only during a write access. `bus_dout` carries the accepted write data throughout a write access.
- R9: A read samples `bus_din` in the last strobe cycle. It raises `rsp_valid` for one cycle, the first hold cycle, with that value on `rsp_rdata`.
- R10: A write raises `wr_done` for one cycle, the first cycle after its last hold cycle.
- R11: Changes to `cfg_word` after a command is accepted do not affect that access.
- R12: After reset, `cmd_ready` is 1, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1, and `bus_oe`, `rsp_valid` and `wr_done` are 0. `cmd_ready` is 0 from acceptance until the access and any turnaround it owes are over, and always 0 while `bus_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Timing configuration word |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| wr_done | output | 1 | Write finished pulse |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dir | output | 1 | Direction, 1 = read |
| bus_oe | output | 1 | Data output enable, write only |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Data driven toward the panel |
| bus_din | input | DATA_W | Data returned by the panel |

## Verification
The bench builds the block with its default 16-bit data width and drives random configuration words over the full field ranges. This reaches 63-cycle strobes, 31-cycle setups, 15-cycle hold counts and every turnaround value. Zero strobe and hold fields are included, which exercises the floor to one cycle. Holding the command valid between transfers makes every inter-access gap exact, so read-after-read skipping and both turnaround orders are measured to the cycle. The bench also rewrites the configuration word in the middle of accesses.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int CFG_W = 32;
  localparam int SU_W  = 5;
  localparam int ST_W  = 6;
  localparam int HD_W  = 4;
  localparam int TA_W  = 2;
  localparam int CNT_W = (ST_W > SU_W) ? ST_W : SU_W;

  // field positions: the layout of the configuration word is fixed
  localparam int WSU_LSB = 27;
  localparam int WST_LSB = 21;
  localparam int WHD_LSB = 17;
  localparam int RSU_LSB = 12;
  localparam int RST_LSB = 6;
  localparam int RHD_LSB = 2;
  localparam int TA_LSB  = 0;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [SU_W-1:0] su;
    logic [ST_W-1:0] st;
    logic [HD_W-1:0] hd;
    logic [TA_W-1:0] ta;
  } timing_t;
endpackage

// File: rtl/pbus_field_decode.sv
module pbus_field_decode
  import pbus_pkg::*;
#(
  parameter int SU_LSB = RSU_LSB,
  parameter int ST_LSB = RST_LSB,
  parameter int HD_LSB = RHD_LSB
) (
  input  logic [CFG_W-1:0] cfg_word,
  output timing_t          timing
);
  logic [ST_W-1:0] st_raw;
  logic [HD_W-1:0] hd_raw;

  always_comb begin
    st_raw    = cfg_word[ST_LSB +: ST_W];
    hd_raw    = cfg_word[HD_LSB +: HD_W];
    timing.su = cfg_word[SU_LSB +: SU_W];
    // zero strobe or hold counts are floored to one cycle
    timing.st = (st_raw == '0) ? ST_W'(1) : st_raw;
    timing.hd = (hd_raw == '0) ? HD_W'(1) : hd_raw;
    timing.ta = cfg_word[TA_LSB +: TA_W];
  end
endmodule

// File: rtl/pbus_phase_ctrl.sv
module pbus_phase_ctrl
  import pbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_valid,
  input  logic    cmd_write,
  input  timing_t t_sel,
  output logic    cmd_ready,
  output logic    accept,
  output phase_e  phase,
  output logic    is_wr,
  output logic    strobe_last,
  output logic    hold_last
);
  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [TA_W-1:0]    gap_q;
  logic               last_wr_q;
  logic               wr_q;
  timing_t            lat_q;

  timing_t            src;
  phase_e             first_ph;
  logic [CNT_W-1:0]   first_cnt;

  // a write just finished still owes its turnaround before any new command
  assign cmd_ready   = (phase_q == PH_IDLE) && !(last_wr_q && (gap_q != '0));
  assign accept      = cmd_valid && cmd_ready;
  assign phase       = phase_q;
  assign is_wr       = wr_q;
  assign strobe_last = (phase_q == PH_STROBE) && (cnt_q == '0);
  assign hold_last   = (phase_q == PH_HOLD) && (cnt_q == '0);

  always_comb begin
    src = (phase_q == PH_IDLE) ? t_sel : lat_q;
    if (src.su != '0) begin
      first_ph  = PH_SETUP;
      first_cnt = CNT_W'(src.su) - CNT_W'(1);
    end else begin
      first_ph  = PH_STROBE;
      first_cnt = CNT_W'(src.st) - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      gap_q     <= '0;
      last_wr_q <= 1'b0;
      wr_q      <= 1'b0;
      lat_q     <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (gap_q != '0) gap_q <= gap_q - TA_W'(1);
          if (accept) begin
            lat_q <= t_sel;
            wr_q  <= cmd_write;
            if (cmd_write && (gap_q != '0)) begin
              phase_q <= PH_WAIT;
            end else begin
              phase_q <= first_ph;
              cnt_q   <= first_cnt;
            end
          end
        end
        PH_WAIT: begin
          if (gap_q == '0) begin
            phase_q <= first_ph;
            cnt_q   <= first_cnt;
          end else begin
            gap_q <= gap_q - TA_W'(1);
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(lat_q.st) - CNT_W'(1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt_q == '0) begin
            phase_q <= PH_HOLD;
            cnt_q   <= CNT_W'(lat_q.hd) - CNT_W'(1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            phase_q   <= PH_IDLE;
            gap_q     <= lat_q.ta;
            last_wr_q <= wr_q;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R11: latched timing is frozen while an access runs
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(lat_q));

  // R6: only a write that follows a read waits out the turnaround after acceptance
  p_wait_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> (wr_q && !last_wr_q));

  // R7: a read taken after a read starts at once
  p_read_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !last_wr_q && accept && !cmd_write)
      |=> (phase_q == PH_SETUP || phase_q == PH_STROBE));
endmodule

// File: rtl/pbus_bus_drive.sv
module pbus_bus_drive
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  phase_e            phase,
  input  logic              is_wr,
  input  logic              strobe_last,
  input  logic              hold_last,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_cs_n,
  output logic              bus_dir,
  output logic              bus_oe,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_done
);
  logic              active;
  logic              strobing;
  logic [DATA_W-1:0] wdata_q;

  assign active   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobing = (phase == PH_STROBE);
  assign bus_cs_n = !active;
  assign bus_dir  = active && !is_wr;
  assign bus_oe   = active && is_wr;
  assign bus_rd_n = !(strobing && !is_wr);
  assign bus_wr_n = !(strobing && is_wr);
  assign bus_dout = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wr_done   <= 1'b0;
    end else begin
      if (accept) wdata_q <= cmd_wdata;
      rsp_valid <= strobe_last && !is_wr;
      if (strobe_last && !is_wr) rsp_rdata <= bus_din;
      wr_done <= hold_last && is_wr;
    end
  end

  // R3: a strobe is only ever low inside chip select
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  // R8: output enable never coincides with a read
  p_oe_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!bus_dir && bus_rd_n));

  // R4: control and data steady throughout chip select
  p_steady_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_dir) && $stable(bus_oe) && $stable(bus_dout)));

  // R9: response appears in the cycle right after the read strobe
  p_rsp_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (bus_rd_n && !bus_cs_n && $past(!bus_rd_n)));

  // R10: write done follows the last hold cycle of a write
  p_done_after_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (bus_cs_n && $past(!bus_cs_n && bus_oe)));
endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_done,
  output logic              bus_cs_n,
  output logic              bus_dir,
  output logic              bus_oe,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int N_SIDES = 2; // index 0 = read fields, 1 = write fields

  timing_t side_t [N_SIDES];
  timing_t t_sel;
  phase_e  phase;
  logic    accept;
  logic    is_wr;
  logic    strobe_last;
  logic    hold_last;

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    pbus_field_decode #(
      .SU_LSB((g == 1) ? WSU_LSB : RSU_LSB),
      .ST_LSB((g == 1) ? WST_LSB : RST_LSB),
      .HD_LSB((g == 1) ? WHD_LSB : RHD_LSB)
    ) u_dec (
      .cfg_word(cfg_word),
      .timing  (side_t[g])
    );
  end

  assign t_sel = cmd_write ? side_t[1] : side_t[0];

  pbus_phase_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .t_sel      (t_sel),
    .cmd_ready  (cmd_ready),
    .accept     (accept),
    .phase      (phase),
    .is_wr      (is_wr),
    .strobe_last(strobe_last),
    .hold_last  (hold_last)
  );

  pbus_bus_drive #(.DATA_W(DATA_W)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .cmd_wdata  (cmd_wdata),
    .phase      (phase),
    .is_wr      (is_wr),
    .strobe_last(strobe_last),
    .hold_last  (hold_last),
    .bus_din    (bus_din),
    .bus_cs_n   (bus_cs_n),
    .bus_dir    (bus_dir),
    .bus_oe     (bus_oe),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_dout   (bus_dout),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .wr_done    (wr_done)
  );

  // R12: no new command can be taken while chip select is active
  p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !cmd_ready);
endmodule

// File: tb/tb_pbus_strobe_timer.sv
module tb_pbus_strobe_timer;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg_word = '0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          wr_done;
  logic          bus_cs_n, bus_dir, bus_oe, bus_rd_n, bus_wr_n;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din = 16'h1234;

  always #2 clk = ~clk; // 250 MHz

  pbus_strobe_timer #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wr_done(wr_done), .bus_cs_n(bus_cs_n), .bus_dir(bus_dir), .bus_oe(bus_oe),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  always @(posedge clk) bus_din <= bus_din * 16'd5 + 16'd7;

  typedef struct {
    int su; int st; int hd; bit wr; logic [DW-1:0] wdata;
    int gap; bit exact; bit both_rd;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  bit   finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [31:0] cfg, bit wr);
    exp_t e;
    e.wr = wr;
    if (wr) begin e.su = cfg[31:27]; e.st = cfg[26:21]; e.hd = cfg[20:17]; end
    else    begin e.su = cfg[16:12]; e.st = cfg[11:6];  e.hd = cfg[5:2];   end
    if (e.st == 0) e.st = 1;
    if (e.hd == 0) e.hd = 1;
    return e;
  endfunction

  // driver state
  bit have_prev = 0;
  bit prev_wr   = 0;
  int prev_ta   = 0;
  bit contig    = 0;

  task automatic issue(bit wr, logic [DW-1:0] wd, logic [31:0] cfg, int idle);
    exp_t e;
    if (idle > 0) begin
      cmd_valid = 1'b0;
      repeat (idle) @(negedge clk);
    end
    cmd_valid = 1'b1; cmd_write = wr; cmd_wdata = wd; cfg_word = cfg;
    while (!cmd_ready) @(negedge clk);
    e = model(cfg, wr);
    e.wdata   = wd;
    e.both_rd = have_prev && !prev_wr && !wr;
    e.gap     = !have_prev ? 0 : (e.both_rd ? 1 : prev_ta + 1);
    e.exact   = have_prev && contig && (idle == 0);
    q.push_back(e);
    have_prev = 1; prev_wr = wr; prev_ta = int'(cfg[1:0]); contig = 1;
    @(negedge clk);
  endtask

  // monitor state
  bit            in_acc = 0;
  bit            seen_strb = 0;
  int            su_c, st_c, hd_c;
  int            idle_run = 0;
  int            meas_su, meas_st, meas_hd;
  logic [DW-1:0] last_din;
  exp_t          cur;

  task automatic drain();
    cmd_valid = 1'b0;
    contig = 0;
    @(negedge clk);
    while (q.size() != 0 || in_acc || !cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!bus_cs_n) begin
        if (!in_acc) begin
          in_acc = 1; seen_strb = 0; su_c = 0; st_c = 0; hd_c = 0;
          if (q.size() == 0) begin
            chk(0, "R12", "access with no accepted command", 1, 0);
            cur = model(32'h0, 1'b0); cur.gap = 0; cur.exact = 0; cur.both_rd = 0; cur.wdata = '0;
          end else cur = q.pop_front();
          if (cur.exact) chk(idle_run == cur.gap, cur.both_rd ? "R7" : "R6", "idle gap", idle_run, cur.gap);
          else           chk(idle_run >= cur.gap, cur.both_rd ? "R7" : "R6", "min idle gap", idle_run, cur.gap);
        end
        chk(cmd_ready == 1'b0, "R12", "ready during access", cmd_ready, 0);
        chk(bus_dir == !cur.wr, "R8", "direction", bus_dir, !cur.wr);
        chk(bus_oe == cur.wr, "R8", "output enable", bus_oe, cur.wr);
        if (cur.wr) chk(bus_dout == cur.wdata, "R8", "write data", bus_dout, cur.wdata);
        if (!bus_rd_n || !bus_wr_n) begin
          seen_strb = 1; st_c++;
          chk(cur.wr ? (!bus_wr_n && bus_rd_n) : (!bus_rd_n && bus_wr_n), "R5", "strobe kind", bus_wr_n, !cur.wr);
          last_din = bus_din;
        end else if (!seen_strb) su_c++;
        else begin
          hd_c++;
          if (hd_c == 1) begin
            chk(rsp_valid == !cur.wr, "R9", "response pulse", rsp_valid, !cur.wr);
            if (!cur.wr) chk(rsp_rdata == last_din, "R9", "read data", rsp_rdata, last_din);
          end
        end
        if (rsp_valid && hd_c != 1) chk(0, "R9", "stray response", 1, 0);
        if (wr_done) chk(0, "R10", "done during access", 1, 0);
      end else begin
        if (rsp_valid) chk(0, "R9", "response outside access", 1, 0);
        if (in_acc) begin
          in_acc = 0;
          chk(su_c == cur.su, "R2", "setup cycles", su_c, cur.su);
          chk(st_c == cur.st, "R3", "strobe cycles", st_c, cur.st);
          chk(hd_c == cur.hd, "R4", "hold cycles", hd_c, cur.hd);
          chk(wr_done == cur.wr, "R10", "done pulse", wr_done, cur.wr);
          meas_su = su_c; meas_st = st_c; meas_hd = hd_c;
          idle_run = 1;
        end else begin
          if (wr_done) chk(0, "R10", "stray done", 1, 0);
          idle_run++;
        end
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic [31:0] cfg_r1;

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(bus_cs_n && bus_rd_n && bus_wr_n, "R12", "bus idle in reset", bus_cs_n, 1);
    chk(!bus_oe && !rsp_valid && !wr_done, "R12", "pulses low in reset", bus_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R12", "ready after reset", cmd_ready, 1);
    chk(bus_cs_n == 1'b1, "R12", "cs idle after reset", bus_cs_n, 1);

    // R1 and R5: distinct field values decoded to their own positions
    cfg_r1 = {5'd3, 6'd2, 4'd1, 5'd1, 6'd4, 4'd2, 2'd0};
    issue(1'b1, 16'hA5C3, cfg_r1, 0);
    drain();
    chk(meas_su == 3 && meas_st == 2 && meas_hd == 1, "R1", "write fields", meas_su*100+meas_st*10+meas_hd, 321);
    issue(1'b0, 16'h0, cfg_r1, 0);
    drain();
    chk(meas_su == 1 && meas_st == 4 && meas_hd == 2, "R1", "read fields", meas_su*100+meas_st*10+meas_hd, 142);

    // R3/R4 floors: all-zero word gives 0 setup, 1 strobe, 1 hold
    issue(1'b1, 16'h0F0F, 32'h0, 0);
    drain();
    chk(meas_su == 0 && meas_st == 1 && meas_hd == 1, "R3", "zero word floors", meas_su*100+meas_st*10+meas_hd, 11);

    // R11: word rewritten right after acceptance
    issue(1'b0, 16'h0, cfg_r1, 0);
    cfg_word = 32'hFFFF_FFFF;
    drain();
    chk(meas_su == 1 && meas_st == 4 && meas_hd == 2, "R11", "fields held", meas_su*100+meas_st*10+meas_hd, 142);

    // R6/R7: back-to-back orders with turnaround 3 and 2
    issue(1'b1, 16'h1111, {5'd0, 6'd1, 4'd1, 5'd0, 6'd1, 4'd1, 2'd3}, 0);
    issue(1'b1, 16'h2222, {5'd2, 6'd1, 4'd1, 5'd0, 6'd1, 4'd1, 2'd3}, 0);
    issue(1'b0, 16'h0,    {5'd0, 6'd1, 4'd1, 5'd0, 6'd2, 4'd1, 2'd3}, 0);
    issue(1'b0, 16'h0,    {5'd0, 6'd1, 4'd1, 5'd1, 6'd1, 4'd1, 2'd2}, 0);
    issue(1'b1, 16'h3333, {5'd0, 6'd3, 4'd2, 5'd0, 6'd1, 4'd1, 2'd1}, 0);
    issue(1'b0, 16'h0,    {5'd0, 6'd1, 4'd1, 5'd0, 6'd1, 4'd1, 2'd0}, 0);
    issue(1'b0, 16'h0,    32'hFFFF_FFFF, 0);
    drain();

    // random mix, mostly back-to-back with the word changing mid-access
    for (int i = 0; i < 250; i++) begin
      int idle;
      idle = (($urandom % 5) == 0) ? int'($urandom % 4) + 1 : 0;
      issue(1'(($urandom % 2)), 16'($urandom), $urandom, idle);
    end
    drain();

    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule